// File: doc/BRIEF.md
# Header-Directed Receive DMA Controller

This block sits between a network-side word stream and a host memory write port. Every incoming packet opens with one 64-bit header word that carries a version tag, a small set of action bits and a destination byte address. The data words that follow are turned into memory write requests at consecutive 8-byte-aligned addresses. No host processor takes part in an ordinary delivery.

Software steers the block through four registers. The first is a control register. The second holds an alternate destination address supplied by the receiver. The last two expose the most recent header, and a write to the low header register doubles as the restart command. The packet's action bits choose the destination and whether an interrupt is requested, and control-register modes can override both choices. After an interrupting packet, or after any packet in debug mode, the stream input stays closed until software restarts it. A packet whose data would run past the page in which it started has its out-of-page words dropped, and a one-cycle error pulse marks the packet.

Top module: `hdr_rx_dma`

## Requirements
- R1: The header word is split as version [63:60], action [59:56], reserved [55:32] and destination byte address [31:0]. After each header is accepted, register select 2 reads back header bits [31:0] and register select 3 reads back header bits [63:32].
- R2: By default, data word i of a packet is written to (header address with bits [2:0] cleared) + 8*i, and the data is unchanged.
- R3: When action bit 0 (header bit 56) is set, the start address comes from the receiver address register (select 1) instead of the header, aligned the same way.
- R4: When control bit 0 is set, every packet uses the receiver address register as its start, whatever its action bits say.
- R5: With control bits [2:1] equal to 0 or 3, irq rises at packet completion exactly when action bit 1 (header bit 57) is set. Completion comes after the final write handshake, so irq never rises while a write is pending.
- R6: Control bits [2:1] = 1 raise irq after every packet, and 2 never raise it, overriding action bit 1.
- R7: Once irq is raised, s_ready stays low and irq stays high until register select 2 is written (restart). The restart clears both, and no header is taken while the path is closed.
- R8: With control bit 3 set, the path closes after every packet, interrupt or not, until a restart.
- R9: Data words whose address falls outside the 2^k-byte page that contains the packet's start address are accepted from the stream but not written. pkt_err pulses for one cycle at the completion of such a packet and stays low otherwise.
- R10: A write request held with w_ready low keeps w_valid, w_addr and w_data stable, and s_ready is low meanwhile.
- R11: After reset, all registers read 0, s_ready is high, and irq and w_valid are low. Writes to select 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 64 | Stream word: header first, then data |
| s_last | input | 1 | Marks the final word of a packet (may be the header) |
| s_ready | output | 1 | Block takes the stream word at this edge |
| w_valid | output | 1 | Memory write request valid |
| w_addr | output | 32 | Write byte address, 8-byte aligned |
| w_data | output | 64 | Write data |
| w_ready | input | 1 | Memory accepts the write |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 receiver address, 2 header low / restart, 3 header high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| irq | output | 1 | Host interrupt, level, cleared by restart |
| pkt_err | output | 1 | One-cycle pulse: packet lost words at a page boundary |

## Verification
The bench builds the block with PAGE_BYTES = 256, so short packets placed near the end of a page reach the boundary-drop path in a few words. With that page size, one sweep covers every combination of the action bits, the three interrupt modes, the address override and the debug freeze, with packet lengths of one to four words and three write-backpressure patterns. Separate cases cover header-only packets, unaligned header addresses, a long write stall and header rejection while the path is closed.

// File: rtl/hdr_rx_pkg.sv
// Shared constants and types for the header-directed receive DMA.
// Assumes a fixed 64-bit header word and 32-bit byte addresses.
package hdr_rx_pkg;

    localparam int HDR_W      = 64;
    localparam int ADDR_W     = 32;
    localparam int BEAT_BYTES = HDR_W / 8;
    localparam int BEAT_LSB   = $clog2(BEAT_BYTES);

    // Register selects
    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_RCV   = 2'd1;
    localparam logic [1:0] SEL_HLO   = 2'd2;  // read: header low, write: restart
    localparam logic [1:0] SEL_HHI   = 2'd3;

    // Interrupt modes in control bits [2:1]
    localparam logic [1:0] IRQ_FOLLOW = 2'd0;
    localparam logic [1:0] IRQ_ALWAYS = 2'd1;
    localparam logic [1:0] IRQ_NEVER  = 2'd2;

    typedef struct packed {
        logic [3:0]  ver;
        logic [3:0]  act;
        logic [23:0] rsvd;
        logic [31:0] dest;
    } rx_hdr_t;

    typedef struct packed {
        logic       dbg_freeze;
        logic [1:0] irq_mode;
        logic       addr_ovr;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_FIN  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/hdr_rx_regs.sv
// Software-visible registers: control, receiver address, captured header.
// A write to SEL_HLO produces a one-cycle restart pulse; SEL_HHI is read-only.
// Assumes reads are combinational on reg_sel.
module hdr_rx_regs
    import hdr_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             hdr_load,
    input  logic [HDR_W-1:0] hdr_in,
    output ctrl_t            ctrl,
    output logic [31:0]      rcv_addr,
    output logic             restart
);

    logic [HDR_W-1:0] hdr_q;

    // Holds control and receiver-address registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            rcv_addr <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_CTRL) ctrl     <= ctrl_t'(reg_wdata[3:0]);
            if (reg_sel == SEL_RCV)  rcv_addr <= reg_wdata;
        end
    end

    // Captures each accepted header for readback.
    always_ff @(posedge clk) begin
        if (!rst_n)        hdr_q <= '0;
        else if (hdr_load) hdr_q <= hdr_in;
    end

    // Decodes the restart command.
    assign restart = reg_we && (reg_sel == SEL_HLO);

    // Read mux.
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {28'd0, ctrl};
            SEL_RCV:  reg_rdata = rcv_addr;
            SEL_HLO:  reg_rdata = hdr_q[31:0];
            default:  reg_rdata = hdr_q[63:32];
        endcase
    end

endmodule

// File: rtl/hdr_rx_policy.sv
// Combines header action bits with control-register overrides to decide
// destination source, interrupt and post-packet freeze. Purely combinational.
module hdr_rx_policy
    import hdr_rx_pkg::*;
(
    input  logic [1:0] act,
    input  ctrl_t      ctrl,
    output logic       use_rcv,
    output logic       want_irq,
    output logic       want_freeze
);

    // Address source: the override bit or the action bit selects the receiver register.
    assign use_rcv = ctrl.addr_ovr | act[0];

    // Interrupt decision: the mode overrides, otherwise the action bit decides.
    always_comb begin
        case (ctrl.irq_mode)
            IRQ_ALWAYS: want_irq = 1'b1;
            IRQ_NEVER:  want_irq = 1'b0;
            default:    want_irq = act[1];
        endcase
    end

    // Freeze after any interrupting packet or always in debug mode.
    assign want_freeze = want_irq | ctrl.dbg_freeze;

endmodule

// File: rtl/hdr_rx_addrgen.sv
// Beat address counter with page-boundary detection. Loads an aligned start
// on a header and steps one beat per data word. Assumes PAGE_BYTES is a power
// of two no smaller than one beat.
module hdr_rx_addrgen #(
    parameter  int ADDR_W     = 32,
    parameter  int PAGE_BYTES = 4096,
    parameter  int BEAT_BYTES = 8,
    localparam int LSB        = $clog2(BEAT_BYTES),
    localparam int PG_BITS    = $clog2(PAGE_BYTES),
    localparam int PGN_W      = ADDR_W - PG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:LSB] start_beat,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              in_page
);

    logic [ADDR_W-LSB-1:0] cur_beat;
    logic [PGN_W-1:0]      base_pg;

    // Tracks the current beat address and the page the packet started in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_beat <= '0;
            base_pg  <= '0;
        end else if (load) begin
            cur_beat <= start_beat;
            base_pg  <= start_beat[ADDR_W-1:PG_BITS];
        end else if (step) begin
            cur_beat <= cur_beat + 1'b1;
        end
    end

    assign cur_addr = {cur_beat, {LSB{1'b0}}};
    assign in_page  = (cur_addr[ADDR_W-1:PG_BITS] == base_pg);

endmodule

// File: rtl/hdr_rx_dma.sv
// Top of the header-directed receive DMA. Accepts header then data words,
// issues one write per in-page data word through a single-entry output
// register, raises irq and closes the input per the policy at completion.
// Assumes the upstream stream never drops s_valid mid-packet semantics matter
// only at handshakes; decisions are fixed when the header is taken.
module hdr_rx_dma
    import hdr_rx_pkg::*;
#(
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [HDR_W-1:0]  s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              w_valid,
    output logic [ADDR_W-1:0] w_addr,
    output logic [HDR_W-1:0]  w_data,
    input  logic              w_ready,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              pkt_err
);

    rx_state_t         state;
    rx_hdr_t           hdr_now;
    ctrl_t             ctrl;
    logic [31:0]       rcv_addr;
    logic              restart;
    logic              use_rcv, want_irq, want_frz;
    logic              irq_pend, frz_pend, drop_seen, frozen;
    logic              wr_free, hdr_fire, beat_fire, done;
    logic [ADDR_W-1:0] start_addr, cur_addr;
    logic              in_page;

    assign hdr_now    = rx_hdr_t'(s_data);
    assign start_addr = use_rcv ? rcv_addr : hdr_now.dest;

    assign wr_free   = !w_valid || w_ready;
    assign s_ready   = ((state == ST_IDLE) && !frozen) || ((state == ST_DATA) && wr_free);
    assign hdr_fire  = s_valid && s_ready && (state == ST_IDLE);
    assign beat_fire = s_valid && s_ready && (state == ST_DATA);
    assign done      = (state == ST_FIN) && wr_free;

    hdr_rx_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hdr_load  (hdr_fire),
        .hdr_in    (s_data),
        .ctrl      (ctrl),
        .rcv_addr  (rcv_addr),
        .restart   (restart)
    );

    hdr_rx_policy u_policy (
        .act         (hdr_now.act[1:0]),
        .ctrl        (ctrl),
        .use_rcv     (use_rcv),
        .want_irq    (want_irq),
        .want_freeze (want_frz)
    );

    hdr_rx_addrgen #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (hdr_fire),
        .start_beat (start_addr[ADDR_W-1:BEAT_LSB]),
        .step       (beat_fire),
        .cur_addr   (cur_addr),
        .in_page    (in_page)
    );

    // Packet sequencing: header, data words, then wait for the last write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (hdr_fire)  state <= s_last ? ST_FIN : ST_DATA;
                ST_DATA: if (beat_fire && s_last) state <= ST_FIN;
                ST_FIN:  if (done)      state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Single-entry write request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_valid <= 1'b0;
            w_addr  <= '0;
            w_data  <= '0;
        end else if (beat_fire && in_page) begin
            w_valid <= 1'b1;
            w_addr  <= cur_addr;
            w_data  <= s_data;
        end else if (w_ready) begin
            w_valid <= 1'b0;
        end
    end

    // Latches the per-packet decisions and records dropped words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend  <= 1'b0;
            frz_pend  <= 1'b0;
            drop_seen <= 1'b0;
        end else if (hdr_fire) begin
            irq_pend  <= want_irq;
            frz_pend  <= want_frz;
            drop_seen <= 1'b0;
        end else if (beat_fire && !in_page) begin
            drop_seen <= 1'b1;
        end
    end

    // Completion effects: interrupt, input freeze, error pulse; restart reopens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            frozen  <= 1'b0;
            pkt_err <= 1'b0;
        end else begin
            pkt_err <= 1'b0;
            if (restart) begin
                irq    <= 1'b0;
                frozen <= 1'b0;
            end
            if (done) begin
                irq     <= irq_pend;
                frozen  <= frz_pend;
                pkt_err <= drop_seen;
            end
        end
    end

endmodule

// File: rtl/hdr_rx_dma_chk.sv
// Property checker for hdr_rx_dma, attached with bind.
module hdr_rx_dma_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ready,
    input logic              w_valid,
    input logic              w_ready,
    input logic [31:0]       w_addr,
    input logic [63:0]       w_data,
    input logic              irq,
    input logic              pkt_err,
    input logic              reg_we,
    input logic [1:0]        reg_sel
);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !w_ready) |=> (w_valid && $stable(w_addr) && $stable(w_data)));

    // R10
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !w_ready) |-> !s_ready);

    // R7
    irq_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !s_ready);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_we && reg_sel == 2'd2)) |=> irq);

    // R5
    irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !w_valid);

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |=> !pkt_err);

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (w_addr[2:0] == 3'b000));

endmodule

bind hdr_rx_dma hdr_rx_dma_chk u_chk (.*);

// File: tb/hdr_rx_dma_bench.sv
module hdr_rx_dma_bench;
    localparam int PG = 256;

    logic        clk = 0, rst_n = 0;
    logic        s_valid = 0, s_last = 0, s_ready;
    logic [63:0] s_data = '0;
    logic        w_valid, w_ready = 1;
    logic [31:0] w_addr;
    logic [63:0] w_data;
    logic        reg_we = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        irq, pkt_err;

    int tests = 0, fails = 0, cyc = 0, rdy_mode = 0;
    int mon_cnt = 0, err_cnt = 0;
    logic [31:0] mon_addr [16];
    logic [63:0] mon_data [16];
    bit busy;

    hdr_rx_dma #(.PAGE_BYTES(PG)) u_hdr_rx_dma (.*);

    initial forever #2 clk = ~clk;

    // backpressure pattern, updated just after each rising edge
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        case (rdy_mode)
            0: w_ready = 1;
            1: w_ready = (cyc % 2) == 0;
            2: w_ready = (cyc % 3) != 0;
            default: w_ready = 0;
        endcase
    end

    // write and error monitor
    initial forever begin
        @(negedge clk); #1;
        if (w_valid && w_ready) begin
            if (mon_cnt < 16) begin
                mon_addr[mon_cnt] = w_addr;
                mon_data[mon_cnt] = w_data;
            end
            mon_cnt++;
        end
        if (pkt_err) err_cnt++;
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        wait (cyc > 100000);
        fails++;
        $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cyc);
        finish_run();
    end

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] s, logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic reg_read(logic [1:0] s, output logic [31:0] v);
        @(negedge clk); reg_sel = s; #1; v = reg_rdata;
    endtask

    task automatic push(logic [63:0] d, bit last);
        @(negedge clk); s_valid = 1; s_data = d; s_last = last;
        #1;
        while (!s_ready) begin @(negedge clk); #1; end
    endtask

    function automatic logic [63:0] word_of(logic [63:0] h, int i);
        return {16'hD000 + 16'(i), h[47:0]};
    endfunction

    task automatic send_pkt(logic [63:0] h, int n);
        push(h, n == 0);
        for (int i = 0; i < n; i++) push(word_of(h, i), i == n - 1);
        @(negedge clk); s_valid = 0; s_last = 0;
    endtask

    task automatic run_check(logic [63:0] h, int n, logic [31:0] rcv, bit ovr, int mode, bit dbg);
        bit use_rcv, eirq, efrz;
        logic [31:0] start, a, v;
        int exp_w;
        string atag;
        use_rcv = ovr | h[56];
        eirq = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : h[57];
        efrz = eirq | dbg;
        start = (use_rcv ? rcv : h[31:0]) & ~32'h7;
        atag = use_rcv ? (ovr ? "R4" : "R3") : "R2";
        reg_write(2'd0, {28'd0, dbg, 2'(mode), ovr});
        reg_write(2'd1, rcv);
        mon_cnt = 0; err_cnt = 0;
        send_pkt(h, n);
        repeat (14) @(negedge clk);
        #1;
        exp_w = 0;
        for (int i = 0; i < n; i++) begin
            a = start + 32'(8 * i);
            if ((a / PG) == (start / PG)) begin
                chk(mon_addr[exp_w] == a, atag, "write address", 64'(mon_addr[exp_w]), 64'(a));
                chk(mon_data[exp_w] == word_of(h, i), "R2", "write data", mon_data[exp_w], word_of(h, i));
                exp_w++;
            end
        end
        chk(mon_cnt == exp_w, "R9", "write count", 64'(mon_cnt), 64'(exp_w));
        chk(err_cnt == ((exp_w < n) ? 1 : 0), "R9", "error pulses", 64'(err_cnt), 64'((exp_w < n) ? 1 : 0));
        chk(irq == eirq, (mode == 0) ? "R5" : "R6", "irq", 64'(irq), 64'(eirq));
        chk(s_ready == !efrz, eirq ? "R7" : "R8", "input open", 64'(s_ready), 64'(!efrz));
        reg_read(2'd2, v);
        chk(v == h[31:0], "R1", "header low", 64'(v), 64'(h[31:0]));
        reg_read(2'd3, v);
        chk(v == h[63:32], "R1", "header high", 64'(v), 64'(h[63:32]));
        if (efrz) begin
            reg_write(2'd2, 32'd0);
            #1;
            chk(s_ready == 1 && irq == 0, "R7", "restart reopens", {s_ready, irq}, 2'b10);
        end
    endtask

    initial begin
        logic [31:0] v;
        logic [63:0] h, hb;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R11 reset state
        chk(s_ready == 1, "R11", "reset s_ready", 64'(s_ready), 1);
        chk(irq == 0 && w_valid == 0, "R11", "reset irq/w_valid", {irq, w_valid}, 0);
        for (int s = 0; s < 4; s++) begin
            reg_read(2'(s), v);
            chk(v == 0, "R11", "reset register", 64'(v), 0);
        end

        // sweep: action x irq mode x override x debug, lengths 1..4
        for (int c = 0; c < 48; c++) begin
            rdy_mode = c % 3;
            h = {4'(c), 4'(c % 4), 24'hA5A5A5 ^ 24'(c), 32'h0001_0000 + 32'(c * PG + 16)};
            run_check(h, 1 + c % 4, 32'h0004_0000 + 32'(c * PG + 64),
                      1'((c / 12) % 2), (c / 4) % 3, 1'((c / 24) % 2));
        end
        rdy_mode = 0;

        // R9 page crossing via header and via receiver address
        run_check({8'h10, 24'h0, 32'h0000_5000 + PG - 16}, 4, 32'h0, 0, 0, 0);
        run_check({8'h11, 24'h0, 32'h0000_6000}, 3, 32'h0000_7000 + PG - 8, 0, 0, 0);
        rdy_mode = 2;
        run_check({8'h10, 24'h0, 32'h0000_5800 + PG - 24}, 4, 32'h0, 0, 3, 0);
        rdy_mode = 0;
        // R2 unaligned header address
        run_check({8'h10, 24'h0, 32'h0000_600D}, 2, 32'h0, 0, 0, 0);
        // R5 header-only packet with interrupt
        run_check({8'h12, 24'h0, 32'h0000_6100}, 0, 32'h0, 0, 0, 0);

        // R10 long stall
        reg_write(2'd0, 32'd0);
        rdy_mode = 3; mon_cnt = 0;
        h = {8'h10, 24'h0, 32'h0000_3000};
        busy = 1;
        fork begin send_pkt(h, 3); busy = 0; end join_none
        repeat (8) @(negedge clk);
        #1;
        chk(w_valid == 1 && s_ready == 0, "R10", "stall holds", {w_valid, s_ready}, 2'b10);
        chk(w_addr == 32'h3000, "R10", "stalled address", 64'(w_addr), 64'h3000);
        chk(mon_cnt == 0, "R10", "no handshake under stall", 64'(mon_cnt), 0);
        rdy_mode = 0;
        wait (busy == 0);
        repeat (8) @(negedge clk);
        #1;
        chk(mon_cnt == 3, "R10", "writes after stall", 64'(mon_cnt), 3);
        chk(mon_addr[2] == 32'h3010, "R10", "last address", 64'(mon_addr[2]), 64'h3010);

        // R7/R8 closed path rejects a new header
        reg_write(2'd0, 32'h8);
        h = {8'h10, 24'h0, 32'h0000_4000};
        send_pkt(h, 1);
        repeat (8) @(negedge clk);
        hb = {8'h10, 24'h0, 32'h0000_4800};
        @(negedge clk); s_valid = 1; s_data = hb; s_last = 1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            chk(s_ready == 0, "R8", "closed after debug packet", 64'(s_ready), 0);
        end
        s_valid = 0; s_last = 0;
        reg_read(2'd2, v);
        chk(v == h[31:0], "R7", "no header taken while closed", 64'(v), 64'(h[31:0]));
        // R11 write to select 3 ignored
        reg_write(2'd3, 32'hFFFF_FFFF);
        reg_read(2'd3, v);
        chk(v == h[63:32], "R11", "select 3 read-only", 64'(v), 64'(h[63:32]));
        reg_write(2'd2, 32'd0);
        #1;
        chk(s_ready == 1, "R8", "restart after debug freeze", 64'(s_ready), 1);

        finish_run();
    end
endmodule